// File: doc/BRIEF.md
# Multiport Crossbar Slave Arbiter

This block is the arbitration and routing core of a crossbar that joins five master ports to four slave ports. Every master presents a request, the index of the slave it wants, a 32-bit address, 64-bit write data and a write flag. Each slave port has its own arbiter. The arbiter picks one of the masters aimed at that slave, routes that master's address and data to the slave, and keeps the grant until the slave signals completion. Masters aimed at different slaves are served in the same cycle.

Arbitration is fair. All masters have equal weight. On each slave port, the search for the next owner starts at the master that follows the one granted last on that port, wrapping from 4 to 0. A master that has not been granted sees its ready output held low. It must keep its request, target and payload stable until ready rises. Read data from the targeted slave is returned to the master on the cycle its ready is high.

Top module: `xbar_arb_core`

## Requirements
- R1: Reset clears every grant lock and sets each slave's last-granted pointer to master 4. The first contention on any slave after reset therefore goes to the lowest-numbered requesting master.
- R2: While a slave port is valid, it carries the owner's address, write data and write flag. It reports the owner's index on its owner output, and that owner requests this slave.
- R3: Masters that target different slave ports are granted and served in the same cycle.
- R4: A master whose request is not the current owner of its target slave sees ready low. At most one master is ready per slave per cycle.
- R5: When a slave is not locked, the grant goes to the first requester found by searching upward from the last granted index plus one, modulo 5.
- R6: Once granted, the owner keeps the slave, and the owner output does not change, until done is seen. This holds even if a master with a better round-robin position starts requesting.
- R7: In a cycle where the owning slave's done is high, the owner's ready is high. The grant is released in that cycle, and a new arbitration takes effect in the next cycle.
- R8: A master's read data output carries the read data of the slave it targets in its ready cycle.
- R9: A slave port with no master targeting it drives its valid output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_req_i | input | 5 | Per-master request |
| m_sel_i | input | 10 | Per-master target slave index, 2 bits each, master 0 in the low bits |
| m_addr_i | input | 160 | Per-master address, 32 bits each |
| m_wdata_i | input | 320 | Per-master write data, 64 bits each |
| m_we_i | input | 5 | Per-master write flag |
| m_ready_o | output | 5 | Per-master transfer complete; low means stalled |
| m_rdata_o | output | 320 | Per-master read data, 64 bits each |
| s_valid_o | output | 4 | Per-slave request valid |
| s_mst_o | output | 12 | Per-slave owner master index, 3 bits each |
| s_addr_o | output | 128 | Per-slave routed address |
| s_wdata_o | output | 256 | Per-slave routed write data |
| s_we_o | output | 4 | Per-slave routed write flag |
| s_done_i | input | 4 | Per-slave transfer done |
| s_rdata_i | input | 256 | Per-slave read data, 64 bits each |

## Verification
The bench sweeps every non-empty set of requesting masters under three target maps. In the first, all masters aim at one slave, which stresses the round-robin order and stalling. In the second, each master aims at a separate slave where possible, which shows parallel service. In the third, two masters share a slave, and in that map the masters outside the starting set join one cycle later, so a locked grant meets a newcomer that has a better round-robin position. Each pattern runs once with zero-wait slaves, which release in the grant cycle, and once with slaves whose done comes late and staggered, which exercises grant holding. Every output is compared in every cycle with an arithmetic model of pointers and locks kept in the bench.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  parameter int XB_N_MST = 5;
  parameter int XB_N_SLV = 4;
  parameter int XB_AW    = 32;
  parameter int XB_DW    = 64;
endpackage

// File: rtl/xbar_rr_pick.sv
// Round-robin pick: search starts at last_i+1 and wraps.
module xbar_rr_pick #(
  parameter int N  = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          any_o,
  output logic [IW-1:0] gnt_id_o
);
  always_comb begin
    any_o    = 1'b0;
    gnt_id_o = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_i) + k) % N;
      if (!any_o && req_i[idx]) begin
        any_o    = 1'b1;
        gnt_id_o = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/xbar_slv_port.sv
// One slave port: grant lock, last-granted pointer and request mux.
module xbar_slv_port #(
  parameter int N_MST = 5,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int MIW  = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MST-1:0]  hit_i,
  input  logic [N_MST*AW-1:0] m_addr_i,
  input  logic [N_MST*DW-1:0] m_wdata_i,
  input  logic [N_MST-1:0]  m_we_i,
  input  logic              done_i,
  output logic              valid_o,
  output logic [MIW-1:0]    owner_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              we_o
);
  logic           lock_q;
  logic [MIW-1:0] lock_id_q;
  logic [MIW-1:0] last_q;
  logic           pick_any;
  logic [MIW-1:0] pick_id;

  xbar_rr_pick #(.N(N_MST)) i_pick (
    .req_i    (hit_i),
    .last_i   (last_q),
    .any_o    (pick_any),
    .gnt_id_o (pick_id)
  );

  assign valid_o = lock_q | pick_any;
  assign owner_o = lock_q ? lock_id_q : pick_id;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q    <= 1'b0;
      lock_id_q <= '0;
      last_q    <= MIW'(N_MST - 1);
    end else if (valid_o) begin
      last_q <= owner_o;
      if (done_i) begin
        lock_q <= 1'b0;
      end else begin
        lock_q    <= 1'b1;
        lock_id_q <= owner_o;
      end
    end
  end

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    we_o    = 1'b0;
    for (int m = 0; m < N_MST; m++) begin
      if (owner_o == MIW'(m)) begin
        addr_o  = m_addr_i[m*AW +: AW];
        wdata_o = m_wdata_i[m*DW +: DW];
        we_o    = m_we_i[m];
      end
    end
  end
endmodule

// File: rtl/xbar_mst_ret.sv
// Master-side return: ready and read data from the targeted slave.
module xbar_mst_ret #(
  parameter int N_MST = 5,
  parameter int N_SLV = 4,
  parameter int DW    = 64,
  localparam int MIW  = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int SIW  = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic [N_MST*SIW-1:0] m_sel_i,
  input  logic [N_SLV-1:0]     s_valid_i,
  input  logic [N_SLV*MIW-1:0] s_mst_i,
  input  logic [N_SLV-1:0]     s_done_i,
  input  logic [N_SLV*DW-1:0]  s_rdata_i,
  output logic [N_MST-1:0]     m_ready_o,
  output logic [N_MST*DW-1:0]  m_rdata_o
);
  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    logic [SIW-1:0] sel;
    assign sel = m_sel_i[m*SIW +: SIW];
    always_comb begin
      m_ready_o[m]          = 1'b0;
      m_rdata_o[m*DW +: DW] = '0;
      for (int s = 0; s < N_SLV; s++) begin
        if (sel == SIW'(s)) begin
          m_rdata_o[m*DW +: DW] = s_rdata_i[s*DW +: DW];
          m_ready_o[m] = s_valid_i[s] && s_done_i[s] &&
                         (s_mst_i[s*MIW +: MIW] == MIW'(m));
        end
      end
    end
  end
endmodule

// File: rtl/xbar_arb_core.sv
module xbar_arb_core
  import xbar_pkg::*;
#(
  parameter int N_MST = XB_N_MST,
  parameter int N_SLV = XB_N_SLV,
  parameter int AW    = XB_AW,
  parameter int DW    = XB_DW,
  localparam int MIW  = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int SIW  = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MST-1:0]     m_req_i,
  input  logic [N_MST*SIW-1:0] m_sel_i,
  input  logic [N_MST*AW-1:0]  m_addr_i,
  input  logic [N_MST*DW-1:0]  m_wdata_i,
  input  logic [N_MST-1:0]     m_we_i,
  output logic [N_MST-1:0]     m_ready_o,
  output logic [N_MST*DW-1:0]  m_rdata_o,
  output logic [N_SLV-1:0]     s_valid_o,
  output logic [N_SLV*MIW-1:0] s_mst_o,
  output logic [N_SLV*AW-1:0]  s_addr_o,
  output logic [N_SLV*DW-1:0]  s_wdata_o,
  output logic [N_SLV-1:0]     s_we_o,
  input  logic [N_SLV-1:0]     s_done_i,
  input  logic [N_SLV*DW-1:0]  s_rdata_i
);
  logic [N_SLV*N_MST-1:0] hit;

  always_comb begin
    for (int s = 0; s < N_SLV; s++) begin
      for (int m = 0; m < N_MST; m++) begin
        hit[s*N_MST + m] = m_req_i[m] && (m_sel_i[m*SIW +: SIW] == SIW'(s));
      end
    end
  end

  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    xbar_slv_port #(.N_MST(N_MST), .AW(AW), .DW(DW)) i_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .hit_i     (hit[s*N_MST +: N_MST]),
      .m_addr_i  (m_addr_i),
      .m_wdata_i (m_wdata_i),
      .m_we_i    (m_we_i),
      .done_i    (s_done_i[s]),
      .valid_o   (s_valid_o[s]),
      .owner_o   (s_mst_o[s*MIW +: MIW]),
      .addr_o    (s_addr_o[s*AW +: AW]),
      .wdata_o   (s_wdata_o[s*DW +: DW]),
      .we_o      (s_we_o[s])
    );
  end

  xbar_mst_ret #(.N_MST(N_MST), .N_SLV(N_SLV), .DW(DW)) i_ret (
    .m_sel_i   (m_sel_i),
    .s_valid_i (s_valid_o),
    .s_mst_i   (s_mst_o),
    .s_done_i  (s_done_i),
    .s_rdata_i (s_rdata_i),
    .m_ready_o (m_ready_o),
    .m_rdata_o (m_rdata_o)
  );
endmodule

// File: rtl/xbar_arb_chk.sv
module xbar_arb_chk #(
  parameter int N_MST = 5,
  parameter int N_SLV = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int MIW  = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int SIW  = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [N_MST-1:0]     m_req_i,
  input logic [N_MST*SIW-1:0] m_sel_i,
  input logic [N_MST*AW-1:0]  m_addr_i,
  input logic [N_MST*DW-1:0]  m_wdata_i,
  input logic [N_MST-1:0]     m_we_i,
  input logic [N_MST-1:0]     m_ready_o,
  input logic [N_MST*DW-1:0]  m_rdata_o,
  input logic [N_SLV-1:0]     s_valid_o,
  input logic [N_SLV*MIW-1:0] s_mst_o,
  input logic [N_SLV*AW-1:0]  s_addr_o,
  input logic [N_SLV*DW-1:0]  s_wdata_o,
  input logic [N_SLV-1:0]     s_we_o,
  input logic [N_SLV-1:0]     s_done_i,
  input logic [N_SLV*DW-1:0]  s_rdata_i
);
  logic [SIW-1:0] sel [N_MST];
  logic [MIW-1:0] own [N_SLV];
  logic [N_SLV-1:0] aimed;

  for (genvar m = 0; m < N_MST; m++) begin : g_sel
    assign sel[m] = m_sel_i[m*SIW +: SIW];
  end

  always_comb begin
    aimed = '0;
    for (int m = 0; m < N_MST; m++) begin
      for (int s = 0; s < N_SLV; s++) begin
        if (m_req_i[m] && sel[m] == SIW'(s)) aimed[s] = 1'b1;
      end
    end
  end

  for (genvar s = 0; s < N_SLV; s++) begin : g_s
    assign own[s] = s_mst_o[s*MIW +: MIW];

    a_r9_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !aimed[s] |-> !s_valid_o[s]);

    a_r2_owner_targets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_valid_o[s] |-> (int'(own[s]) < N_MST) && m_req_i[own[s]] &&
                       (sel[own[s]] == SIW'(s)));

    a_r6_hold_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_valid_o[s] && !s_done_i[s] |=> s_valid_o[s] && $stable(own[s]));

    a_r7_done_readies_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_valid_o[s] && s_done_i[s] |-> (int'(own[s]) < N_MST) && m_ready_o[own[s]]);
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_m
    a_r4_ready_only_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_ready_o[m] |-> (int'(sel[m]) < N_SLV) && s_valid_o[sel[m]] &&
                       (own[sel[m]] == MIW'(m)) && s_done_i[sel[m]]);
  end
endmodule

bind xbar_arb_core xbar_arb_chk #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW)) i_chk (.*);

// File: tb/test_xbar_arb_core.sv
module test_xbar_arb_core;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 5, NS = 4, AW = 32, DW = 64, MIW = 3, SIW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NM-1:0]     m_req_i = '0;
  logic [NM*SIW-1:0] m_sel_i = '0;
  logic [NM*AW-1:0]  m_addr_i = '0;
  logic [NM*DW-1:0]  m_wdata_i = '0;
  logic [NM-1:0]     m_we_i = '0;
  logic [NM-1:0]     m_ready_o;
  logic [NM*DW-1:0]  m_rdata_o;
  logic [NS-1:0]     s_valid_o;
  logic [NS*MIW-1:0] s_mst_o;
  logic [NS*AW-1:0]  s_addr_o;
  logic [NS*DW-1:0]  s_wdata_o;
  logic [NS-1:0]     s_we_o;
  logic [NS-1:0]     s_done_i = '0;
  logic [NS*DW-1:0]  s_rdata_i = '0;

  xbar_arb_core i_xbar_arb_core (
    .clk_i(clk), .rst_ni(rst_ni), .m_req_i(m_req_i), .m_sel_i(m_sel_i),
    .m_addr_i(m_addr_i), .m_wdata_i(m_wdata_i), .m_we_i(m_we_i),
    .m_ready_o(m_ready_o), .m_rdata_o(m_rdata_o), .s_valid_o(s_valid_o),
    .s_mst_o(s_mst_o), .s_addr_o(s_addr_o), .s_wdata_o(s_wdata_o),
    .s_we_o(s_we_o), .s_done_i(s_done_i), .s_rdata_i(s_rdata_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int last_s[NS], lock_s[NS], lkid_s[NS], tgt[NM];
  bit pend[NM];
  bit first_after_rst[NS];

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cyc=%0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  function automatic logic [AW-1:0] addr_of(int m);
    return 32'hA000_0000 | AW'(m << 8) | AW'(cyc & 8'hff);
  endfunction
  function automatic logic [DW-1:0] data_of(int m);
    return {32'(m) ^ 32'h5a5a_0000, 32'hC0DE_0000 | 32'(cyc)};
  endfunction

  // expected owner of slave s, from pointer and lock (R5/R6)
  function automatic int exp_owner(int s);
    if (lock_s[s] != 0) return lkid_s[s];
    for (int k = 1; k <= NM; k++) begin
      int idx;
      idx = (last_s[s] + k) % NM;
      if (pend[idx] && tgt[idx] == s) return idx;
    end
    return -1;
  endfunction

  task automatic step(input logic [NS-1:0] done);
    int own[NS];
    bit served[NM];
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      m_req_i[m]              = pend[m];
      m_sel_i[m*SIW +: SIW]   = SIW'(tgt[m]);
      m_addr_i[m*AW +: AW]    = addr_of(m);
      m_wdata_i[m*DW +: DW]   = data_of(m);
      m_we_i[m]               = m[0];
    end
    s_done_i = done;
    for (int s = 0; s < NS; s++) s_rdata_i[s*DW +: DW] = {32'(s) | 32'hBEEF_0000, 32'(cyc)};
    #1;
    for (int s = 0; s < NS; s++) begin
      own[s] = exp_owner(s);
      if (own[s] < 0) begin
        chk(s_valid_o[s] == 1'b0, "R9", "idle slave valid", 64'(s_valid_o[s]), 64'd0);
      end else begin
        chk(s_valid_o[s] == 1'b1, "R3", "slave valid", 64'(s_valid_o[s]), 64'd1);
        if (first_after_rst[s])
          chk(int'(s_mst_o[s*MIW +: MIW]) == own[s], "R1", "first owner", 64'(s_mst_o[s*MIW +: MIW]), 64'(own[s]));
        else if (lock_s[s] != 0)
          chk(int'(s_mst_o[s*MIW +: MIW]) == own[s], "R6", "held owner", 64'(s_mst_o[s*MIW +: MIW]), 64'(own[s]));
        else
          chk(int'(s_mst_o[s*MIW +: MIW]) == own[s], "R5", "rr owner", 64'(s_mst_o[s*MIW +: MIW]), 64'(own[s]));
        chk(s_addr_o[s*AW +: AW] == addr_of(own[s]), "R2", "addr", 64'(s_addr_o[s*AW +: AW]), 64'(addr_of(own[s])));
        chk(s_wdata_o[s*DW +: DW] == data_of(own[s]), "R2", "wdata", s_wdata_o[s*DW +: DW], data_of(own[s]));
        chk(s_we_o[s] == 1'(own[s] & 1), "R2", "we", 64'(s_we_o[s]), 64'(own[s] & 1));
      end
    end
    for (int m = 0; m < NM; m++) begin
      bit er;
      er = pend[m] && own[tgt[m]] == m && done[tgt[m]];
      served[m] = er;
      if (pend[m] && own[tgt[m]] == m)
        chk(m_ready_o[m] == er, "R7", "owner ready", 64'(m_ready_o[m]), 64'(er));
      else
        chk(m_ready_o[m] == 1'b0, "R4", "stalled ready", 64'(m_ready_o[m]), 64'd0);
      if (er)
        chk(m_rdata_o[m*DW +: DW] == s_rdata_i[tgt[m]*DW +: DW], "R8", "rdata",
            m_rdata_o[m*DW +: DW], s_rdata_i[tgt[m]*DW +: DW]);
    end
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin
      if (own[s] >= 0) begin
        first_after_rst[s] = 1'b0;
        last_s[s] = own[s];
        if (done[s]) lock_s[s] = 0;
        else begin lock_s[s] = 1; lkid_s[s] = own[s]; end
      end
    end
    for (int m = 0; m < NM; m++) if (served[m]) pend[m] = 1'b0;
    cyc++;
  endtask

  function automatic logic [NS-1:0] done_pat(int dm);
    logic [NS-1:0] d;
    for (int s = 0; s < NS; s++) d[s] = (dm == 0) ? 1'b1 : ((cyc + s) % 3 == 2);
    return d;
  endfunction

  task automatic run_scn(int mask, int tm, int dm);
    int late;
    late = (tm == 2) ? (~mask & 5'h1f) : 0;
    for (int m = 0; m < NM; m++) begin
      pend[m] = mask[m];
      case (tm)
        0: tgt[m] = 0;
        1: tgt[m] = m % NS;
        default: tgt[m] = (m * 3 + 1) % NS;
      endcase
    end
    for (int k = 0; k < 60; k++) begin
      bit busy;
      if (k == 1) for (int m = 0; m < NM; m++) if (late[m]) pend[m] = 1'b1;
      busy = 1'b0;
      for (int m = 0; m < NM; m++) busy |= pend[m];
      if (!busy && k >= 1) break;
      step(done_pat(dm));
    end
    for (int m = 0; m < NM; m++)
      chk(pend[m] == 1'b0, "R7", "all served", 64'(pend[m]), 64'd0);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      last_s[s] = NM - 1; lock_s[s] = 0; lkid_s[s] = 0; first_after_rst[s] = 1'b1;
    end
    for (int m = 0; m < NM; m++) begin pend[m] = 1'b0; tgt[m] = 0; end
    #(CLK_PERIOD * 3);
    chk(s_valid_o == '0, "R1", "reset valid", 64'(s_valid_o), 64'd0);
    chk(m_ready_o == '0, "R1", "reset ready", 64'(m_ready_o), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: first contention after reset, masters 1,3 on slave 3 and 2,4 on slave 1
    pend[1] = 1; tgt[1] = 3; pend[3] = 1; tgt[3] = 3;
    pend[2] = 1; tgt[2] = 1; pend[4] = 1; tgt[4] = 1;
    for (int k = 0; k < 4; k++) step(4'b1111);
    for (int s = 0; s < NS; s++) first_after_rst[s] = 1'b0;
    for (int mask = 1; mask < 32; mask++)
      for (int tm = 0; tm < 3; tm++)
        for (int dm = 0; dm < 2; dm++)
          run_scn(mask, tm, dm);
    report();
    $finish;
  end
endmodule